// File: doc/BRIEF.md
# Flash Line Buffer and Wait-State Sequencer

This block sits between a processor read port and a slow, line-wide flash array. Each request is a 64-bit double-word read. The block keeps the most recently fetched 256-bit line in a read buffer. After every line fill it fetches the next sequential line into a single prefetch register, without being asked. A request therefore completes in one of three latency classes:
- a full programmable wait count when the line is held nowhere;
- no wait at all when the read buffer already holds the line;
- one wait when the prefetch register holds the line, which then moves into the read buffer.

Two 4-bit wait fields set the full-wait count, one for the program region and one for the data region. They live in a small configuration register inside the block, and software writes both through a single write strobe. Both fields reset to a worst-case count, so the block is safe at any clock rate. Software lowers them to match the clock frequency. Typical counts rise with the clock: 1 at or below 37.5 MHz, then 2, 3, 4 and 5 as the clock climbs towards 180 MHz.

Requests and responses use valid/ready handshakes:
- The request side takes one read at a time. It raises `req_ready` only while no read is in progress and no response is waiting.
- A response, once raised, holds its valid and data unchanged until `rsp_ready` is seen high at a clock edge.
- The array side is a plain read strobe with a line address. The array must present that line's data within one cycle, and hold it until the next strobe.

Top module: `fbuf_ws_ctrl`

## Requirements
- R1: Out of reset, both wait fields are 15, the read buffer and prefetch register are empty, `req_ready` is 1, `rsp_valid` is 0 and no array read is issued.
- R2: A read whose line is in neither buffer raises `rsp_valid` W cycles later than a zero-wait read would. W is the wait field of the request's region.
- R3: Address bit AW-1 picks the region: 0 uses the program wait field, 1 uses the data wait field.
- R4: The line address is `req_addr[AW-1:5]` and the double-word select is `req_addr[4:3]`. A read whose line is in the read buffer raises `rsp_valid` in the cycle right after acceptance, with the selected double-word.
- R5: After a line fill from the array, the block fetches the following line (line address + 1) into the prefetch register. That fetch takes the wait count of the prefetched line's region.
- R6: A read that hits the filled prefetch register completes one cycle later than a buffer hit. Its line becomes the read-buffer line, and the line after it is prefetched.
- R7: A read that misses both buffers while a prefetch is in flight cancels that prefetch and empties the prefetch register. The read then takes its full wait count.
- R8: A configuration write that changes either field empties both the read buffer and the prefetch register. A write of unchanged values leaves them intact.
- R9: A wait field of 0 behaves as 1.
- R10: While a response waits with `rsp_ready` low, `rsp_valid` stays 1, `rsp_data` holds, and `req_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for both wait fields |
| cfg_ws_prog | input | 4 | New program-region wait count |
| cfg_ws_data | input | 4 | New data-region wait count |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a read |
| req_addr | input | AW | Byte address of the double-word (bits 2:0 zero) |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | DW | Double-word read data |
| fl_rd_en | output | 1 | Array line read strobe |
| fl_line | output | AW-5 | Array line address |
| fl_rdata | input | LB | Array line data, valid one cycle after the strobe |

## Verification
The bench goes after the timing edges between the three latency classes:
- It reads the first line at the reset count of 15. A block that did not reset the fields to worst case would answer early.
- It reads the line after a filled one. A block without an automatic prefetch would charge the full wait there, and one that skipped the handover would miss on the next read to that line.
- It follows one miss at once with a miss on the line being prefetched. A block that let the old fetch run would return the wrong line or the wrong latency.
- It rewrites the wait fields and re-reads a buffered line. A block that kept stale lines would answer with zero wait instead of the new count, while a block that also flushed on an identical write would lose a hit.
- A field of zero and a held-off response round out the cases.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  localparam int WSW = 4;
  localparam logic [WSW-1:0] WS_RESET = '1;

  typedef enum logic [1:0] {DM_IDLE, DM_WAIT, DM_RESP} dm_state_e;
  typedef enum logic [1:0] {PF_IDLE, PF_ARM, PF_BUSY} pf_state_e;

  // Fields of zero are stretched to one cycle: the array needs a cycle.
  function automatic logic [WSW-1:0] eff_wait(input logic [WSW-1:0] f);
    return (f == '0) ? WSW'(1) : f;
  endfunction
endpackage

// File: rtl/fbw_cfg_reg.sv
module fbw_cfg_reg
  import fbw_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [WSW-1:0] wr_prog,
  input  logic [WSW-1:0] wr_data,
  output logic [WSW-1:0] ws_prog,
  output logic [WSW-1:0] ws_data,
  output logic           chg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prog <= WS_RESET;
      ws_data <= WS_RESET;
    end else if (we) begin
      ws_prog <= wr_prog;
      ws_data <= wr_data;
    end
  end

  assign chg = we && ((wr_prog != ws_prog) || (wr_data != ws_data));

  // R1: fields only move on a write strobe
  a_r1_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(ws_prog) && $stable(ws_data)));
  // R8: a change pulse lands the new values
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ws_prog == $past(wr_prog) && ws_data == $past(wr_data)));
endmodule

// File: rtl/fbw_wait_timer.sv
module fbw_wait_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  input  logic          abort,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= load;
    else if (abort)        cnt <= '0;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  // R2: a running count steps down by one each cycle
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && !abort) |=> (cnt == $past(cnt) - 1'b1));
  // R7: an abort with no restart clears the count
  a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start) |=> !busy);
endmodule

// File: rtl/fbw_line_store.sv
module fbw_line_store #(
  parameter int LW = 19,
  parameter int LB = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [LW-1:0] wr_line,
  input  logic [LB-1:0] wr_data,
  input  logic          inval,
  input  logic [LW-1:0] q_line,
  output logic          hit,
  output logic          valid_o,
  output logic [LB-1:0] data_o
);
  logic [LW-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid_o <= 1'b0;
    else if (inval)  valid_o <= 1'b0;
    else if (wr)     valid_o <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      data_o <= '0;
    end else if (wr) begin
      line_q <= wr_line;
      data_o <= wr_data;
    end
  end

  assign hit = valid_o && (line_q == q_line);

  // R8: an invalidate always empties the store
  a_r8_inval_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> !valid_o);
endmodule

// File: rtl/fbuf_ws_ctrl.sv
module fbuf_ws_ctrl
  import fbw_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 64,
  parameter int LB = 256
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [3:0]                  cfg_ws_prog,
  input  logic [3:0]                  cfg_ws_data,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [AW-1:0]               req_addr,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [DW-1:0]               rsp_data,
  output logic                        fl_rd_en,
  output logic [AW-$clog2(LB/8)-1:0]  fl_line,
  input  logic [LB-1:0]               fl_rdata
);
  localparam int OFF  = $clog2(LB / 8);
  localparam int BOFF = $clog2(DW / 8);
  localparam int SELW = OFF - BOFF;
  localparam int DWL  = $clog2(DW);
  localparam int LW   = AW - OFF;

  // configuration
  logic [WSW-1:0] ws_prog, ws_data;
  logic           cfg_chg;

  fbw_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .wr_prog(cfg_ws_prog), .wr_data(cfg_ws_data),
    .ws_prog(ws_prog), .ws_data(ws_data), .chg(cfg_chg)
  );

  // request decode
  logic [LW-1:0]   req_line;
  logic [SELW-1:0] req_sel;
  logic [WSW-1:0]  ws_req;
  assign req_line = req_addr[AW-1:OFF];
  assign req_sel  = req_addr[OFF-1:BOFF];
  assign ws_req   = eff_wait(req_addr[AW-1] ? ws_data : ws_prog);

  dm_state_e       dm_state;
  pf_state_e       pf_state;
  logic            dm_fl;
  logic [LW-1:0]   dm_line;
  logic [SELW-1:0] dm_sel;
  logic [LW-1:0]   pf_tgt;

  logic acc, rb_hit, pf_hit, acc_bhit, acc_phit, acc_miss;
  logic rb_valid, pf_valid;
  logic [LB-1:0] rb_data, pf_data;

  assign req_ready = (dm_state == DM_IDLE);
  assign rsp_valid = (dm_state == DM_RESP);
  assign acc       = req_valid && req_ready;
  assign acc_bhit  = acc && rb_hit;
  assign acc_phit  = acc && !rb_hit && pf_hit;
  assign acc_miss  = acc && !rb_hit && !pf_hit;

  // demand timer
  logic dm_tbusy, dm_tdone, dm_done;
  fbw_wait_timer #(.CW(WSW)) u_dm_tmr (
    .clk(clk), .rst_n(rst_n),
    .start(acc_miss || acc_phit),
    .load(acc_miss ? ws_req : WSW'(1)),
    .abort(1'b0),
    .busy(dm_tbusy), .done(dm_tdone)
  );
  assign dm_done = (dm_state == DM_WAIT) && dm_tdone;

  // prefetch control
  logic          pf_kill, pf_arm, pf_launch, pf_tbusy, pf_tdone, pf_fill;
  logic [LW-1:0] pf_next;
  assign pf_kill   = cfg_chg || acc_miss;
  assign pf_arm    = (dm_done && dm_fl) || acc_phit;
  assign pf_next   = (acc_phit ? req_line : dm_line) + 1'b1;
  assign pf_launch = (pf_state == PF_ARM) && !pf_kill &&
                     !((dm_state == DM_WAIT) && dm_fl);
  assign pf_fill   = (pf_state == PF_BUSY) && pf_tdone && !pf_kill;

  fbw_wait_timer #(.CW(WSW)) u_pf_tmr (
    .clk(clk), .rst_n(rst_n),
    .start(pf_launch),
    .load(eff_wait(pf_tgt[LW-1] ? ws_data : ws_prog)),
    .abort(pf_kill),
    .busy(pf_tbusy), .done(pf_tdone)
  );

  // line stores
  fbw_line_store #(.LW(LW), .LB(LB)) u_rbuf (
    .clk(clk), .rst_n(rst_n),
    .wr((dm_done && dm_fl) || acc_phit),
    .wr_line(acc_phit ? req_line : dm_line),
    .wr_data(acc_phit ? pf_data : fl_rdata),
    .inval(cfg_chg),
    .q_line(req_line),
    .hit(rb_hit), .valid_o(rb_valid), .data_o(rb_data)
  );

  fbw_line_store #(.LW(LW), .LB(LB)) u_pfreg (
    .clk(clk), .rst_n(rst_n),
    .wr(pf_fill), .wr_line(pf_tgt), .wr_data(fl_rdata),
    .inval(pf_kill || acc_phit),
    .q_line(req_line),
    .hit(pf_hit), .valid_o(pf_valid), .data_o(pf_data)
  );

  // array port: demand misses win over prefetch launches
  assign fl_rd_en = acc_miss || pf_launch;
  assign fl_line  = acc_miss ? req_line : pf_tgt;

  // double-word select
  logic [SELW-1:0]      sel_mux;
  logic [SELW+DWL-1:0]  word_idx;
  logic [DW-1:0]        rb_word, fl_word;
  assign sel_mux  = (dm_state == DM_IDLE) ? req_sel : dm_sel;
  assign word_idx = {sel_mux, {DWL{1'b0}}};
  assign rb_word  = rb_data[word_idx +: DW];
  assign fl_word  = fl_rdata[word_idx +: DW];

  // demand sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dm_state <= DM_IDLE;
      dm_fl    <= 1'b0;
      dm_line  <= '0;
      dm_sel   <= '0;
      rsp_data <= '0;
    end else begin
      unique case (dm_state)
        DM_IDLE: begin
          if (acc) begin
            dm_line <= req_line;
            dm_sel  <= req_sel;
            dm_fl   <= acc_miss;
          end
          if (acc_bhit) begin
            rsp_data <= rb_word;
            dm_state <= DM_RESP;
          end else if (acc) begin
            dm_state <= DM_WAIT;
          end
        end
        DM_WAIT: if (dm_done) begin
          rsp_data <= dm_fl ? fl_word : rb_word;
          dm_state <= DM_RESP;
        end
        DM_RESP: if (rsp_ready) dm_state <= DM_IDLE;
        default: dm_state <= DM_IDLE;
      endcase
    end
  end

  // prefetch sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_state <= PF_IDLE;
      pf_tgt   <= '0;
    end else if (pf_kill) begin
      pf_state <= PF_IDLE;
    end else if (pf_arm) begin
      pf_state <= PF_ARM;
      pf_tgt   <= pf_next;
    end else begin
      unique case (pf_state)
        PF_ARM:  if (pf_launch) pf_state <= PF_BUSY;
        PF_BUSY: if (pf_tdone)  pf_state <= PF_IDLE;
        default: pf_state <= PF_IDLE;
      endcase
    end
  end

  // requests are double-word aligned
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[BOFF-1:0] == '0));
  // R4: buffer hits answer in the next cycle
  a_r4_hit_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bhit |=> rsp_valid);
  // R6: prefetch hits answer one cycle later than a buffer hit
  a_r6_pf_one_wait: assert property (@(posedge clk) disable iff (!rst_n)
    acc_phit |=> (!rsp_valid && dm_tbusy));
  a_r6_pf_lands: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_phit, 2) |-> (rsp_valid && rb_valid));
  // R7: a demand miss leaves no prefetch behind
  a_r7_miss_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss |=> (!pf_valid && !pf_tbusy && pf_state == PF_IDLE));
  // R8: a field change empties both stores
  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (!rb_valid && !pf_valid));
  // R10: a held response keeps valid and data
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && !req_ready));
endmodule

// File: tb/sim_fbuf_ws_ctrl.sv
module sim_fbuf_ws_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 64;
  localparam int LB = 256;
  localparam int LW = AW - 5;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_ws_prog = '0;
  logic [3:0]    cfg_ws_data = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic          fl_rd_en;
  logic [LW-1:0] fl_line;
  logic [LB-1:0] fl_rdata = '0;

  fbuf_ws_ctrl #(.AW(AW), .DW(DW), .LB(LB)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ws_prog(cfg_ws_prog), .cfg_ws_data(cfg_ws_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .fl_rd_en(fl_rd_en), .fl_line(fl_line), .fl_rdata(fl_rdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // array stub: one-cycle, line-wide
  function automatic logic [DW-1:0] dword_of(logic [LW-1:0] ln, logic [1:0] k);
    return {16'hF1A5, 14'd0, k, 32'(ln)};
  endfunction

  function automatic logic [LB-1:0] line_img(logic [LW-1:0] ln);
    logic [LB-1:0] img;
    for (int k = 0; k < 4; k++) img[k*DW +: DW] = dword_of(ln, 2'(k));
    return img;
  endfunction

  always @(posedge clk) if (fl_rd_en) fl_rdata <= line_img(fl_line);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [DW-1:0] q_data[$];
  int            q_due[$];
  string         q_tag[$];
  bit            seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !finished && rsp_valid) begin
      if (q_data.size() == 0) begin
        check(1'b0, "R10 unexpected response", 1, 0);
      end else begin
        if (!seen) begin
          seen = 1'b1;
          check(cyc == q_due[0], {q_tag[0], " latency"}, cyc, q_due[0]);
        end
        if (rsp_ready) begin
          check(rsp_data == q_data[0], {q_tag[0], " data"}, rsp_data, q_data[0]);
          void'(q_data.pop_front());
          void'(q_due.pop_front());
          void'(q_tag.pop_front());
          seen = 1'b0;
        end
      end
    end
  end

  task automatic issue(input logic [AW-1:0] a, input int w, input string tag);
    @(negedge clk);
    req_addr  = a;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    q_data.push_back(dword_of(a[AW-1:5], a[4:3]));
    q_due.push_back(cyc + 1 + w);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    while (q_data.size() != 0) @(negedge clk);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [3:0] p, input logic [3:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ws_prog = p; cfg_ws_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !finished) begin
      check(1'b0, "watchdog", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    check(fl_rd_en == 1'b0, "R1 fl_rd_en", fl_rd_en, 0);

    // R1 R2: first miss pays the reset count of 15
    issue(24'h000100, 15, "R1 R2 reset-count miss");
    drain(20);
    // R4: hit on another double-word of the same line
    issue(24'h000108, 0, "R4 buffer hit");
    drain(20);
    // R5 R6: next line arrived by prefetch
    issue(24'h000130, 1, "R5 R6 prefetch hit");
    issue(24'h000138, 0, "R6 moved into buffer");
    drain(2);

    // R8: changed fields flush the buffer
    cfg_write(4'd3, 4'd5);
    issue(24'h000120, 3, "R8 flushed line misses");
    drain(8);

    // R3: data region uses its own field
    issue(24'h800040, 5, "R3 data-region miss");
    drain(10);
    issue(24'h800048, 0, "R3 R4 data-region hit");
    drain(10);
    issue(24'h800060, 1, "R5 data-region prefetch hit");
    drain(8);

    // R7: a miss on the line being prefetched aborts it
    issue(24'h000400, 3, "R2 program miss");
    issue(24'h000420, 3, "R7 abort in-flight prefetch");
    drain(8);
    issue(24'h000440, 1, "R7 prefetch restarted");
    issue(24'h000448, 0, "R6 after restart");
    drain(4);

    // R9: field of zero acts as one
    cfg_write(4'd0, 4'd5);
    issue(24'h000500, 1, "R9 zero field");
    drain(4);
    // R8: rewriting the same values keeps the buffer
    cfg_write(4'd0, 4'd5);
    issue(24'h000508, 0, "R8 same-value write keeps line");
    drain(2);

    // R10: back-pressure holds the response
    @(posedge clk); #1 rsp_ready = 1'b0;
    issue(24'h000510, 0, "R10 held hit");
    begin
      logic [DW-1:0] first;
      first = rsp_data;
      check(rsp_valid == 1'b1, "R10 valid raised", rsp_valid, 1);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(rsp_valid == 1'b1, "R10 valid held", rsp_valid, 1);
        check(rsp_data == first, "R10 data held", rsp_data, first);
        check(req_ready == 1'b0, "R10 no accept while held", req_ready, 0);
      end
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    drain(4);
    check(q_data.size() == 0, "R10 scoreboard empty", q_data.size(), 0);
    finish_run();
  end
endmodule